// File: doc/BRIEF.md
# Programmable LED Blink Controller

This block drives one LED with a programmable on/off waveform and raises an interrupt when a counted blink sequence ends. Software sets it up through four word registers on a simple synchronous write port with a combinational read port. A prescaler turns the core clock into ticks. A period counter advances on each tick, and a duty compare decides how many ticks of every period the LED stays lit.

The tick rate comes from a 4-bit rate field. Rate 0 selects the slowest tick, which is one tick every 8192 clocks. Each step up halves the tick interval, so rate 13 ticks on every clock. An optional auto-stop mode counts whole periods down from a loaded value. When the last period completes, the block turns the LED function off and flags an interrupt request, which a mask bit can hide.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every register reads 0, `led_out` is 0 and `irq` is 0.
- R2: Registers are decoded from address bits [3:2]: 0 = control (7 bits), 1 = period (12 bits), 2 = duty (12 bits), 3 = stop count (16 bits). Unused upper bits read as 0.
- R3: Control bits [3:0] hold the rate value n. The counter advances once every 2^(13-n) clocks, so at time t clocks after enabling, the count is floor(t / 2^(13-n)) mod (P+1).
- R4: Rate values 14 and 15 act as 13, which is one tick per clock. The control register still reads back the value written.
- R5: With period value P, a period lasts P+1 ticks. After a tick at a count of P or more, the counter returns to 0.
- R6: `led_out` is 1 while the count is below the duty value D and 0 otherwise. D = 0 keeps the LED dark, and D > P keeps it lit.
- R7: Control bit 4 is the enable. While it is 0, `led_out` is 0 and the prescaler and counter are held at zero, so each enable starts at count 0.
- R8: With control bit 5 (auto-stop) set, the stop count decrements at each period end while it is above 1, and reads back the remaining count.
- R9: With auto-stop set, the period end that finds the stop count at 1 or 0 clears control bit 4 and the stop count, drives `led_out` low, and sets the interrupt pending flag. A loaded count N ≥ 1 therefore gives exactly N periods.
- R10: `irq` equals the pending flag while control bit 6 (mask) is 0. `irq` is always 0 while the mask bit is 1.
- R11: Any write to the control register clears the pending flag.
- R12: With auto-stop clear, the stop count never changes except by a write, and blinking continues indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address; bits [3:2] pick the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| led_out | output | 1 | LED drive level |
| irq | output | 1 | Interrupt request, active high |

## Verification
The waveform is tried with random rate values from 10 to 15, periods of 0 to 15, and duty values on both sides of the period. These runs separate errors in the tick divisor, in the wrap point and in the duty compare, and rates 14 and 15 expose a missing clamp. Auto-stop is tried with counts of 0 to 3, with the mask set and clear, and with auto-stop off while a count is loaded. These cases separate an off-by-one in the period count, a stop that leaves the LED lit, a mask that leaks, and a count that moves when it should hold. Directed cases cover the slowest rate at its first tick boundary, full-width readback, and clearing of the pending flag by a control write.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  localparam int MAX_LOG2 = 13;
  localparam int RATE_W   = 4;
  localparam int EN_BIT   = 4;
  localparam int AS_BIT   = 5;
  localparam int MASK_BIT = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_STOP = 2'd3
  } reg_sel_e;

  // rate values above the top are treated as the top
  function automatic logic [RATE_W-1:0] eff_rate(input logic [RATE_W-1:0] raw);
    return (raw > RATE_W'(MAX_LOG2)) ? RATE_W'(MAX_LOG2) : raw;
  endfunction

  // low-bit mask of the prescaler that must be all ones for a tick
  function automatic logic [MAX_LOG2-1:0] tick_mask(input logic [RATE_W-1:0] raw);
    logic [MAX_LOG2-1:0] all_ones;
    all_ones = '1;
    return all_ones >> eff_rate(raw);
  endfunction

endpackage

// File: rtl/led_blink_prescaler.sv
module led_blink_prescaler
  import led_blink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [MAX_LOG2-1:0] pre_cnt;
  logic [MAX_LOG2-1:0] mask;

  assign mask = tick_mask(rate);
  assign tick = en && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (!en)    pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick); // R7

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_cnt == '0); // R7

endmodule

// File: rtl/led_blink_waveform.sv
module led_blink_waveform #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] duty,
  output logic [PER_W-1:0] count,
  output logic             period_end,
  output logic             led
);

  assign period_end = tick && (count >= period);
  assign led        = en && (count < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!en)        count <= '0;
    else if (period_end) count <= '0;
    else if (tick)       count <= count + 1'b1;
  end

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> count == '0); // R5

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && $past(en)) |=> $stable(count)); // R3

endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs
  import led_blink_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CTRL_W = 7,
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              period_end,
  output logic              en,
  output logic              irq_mask,
  output logic [RATE_W-1:0] rate,
  output logic [PER_W-1:0]  period,
  output logic [PER_W-1:0]  duty,
  output logic              pending
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  duty_q;
  logic [STOP_W-1:0] stop_q;
  logic              pend_q;
  reg_sel_e          sel;

  logic wr_ctrl, wr_per, wr_duty, wr_stop;
  logic auto_on, stop_hit, stop_evt, dec_evt;

  assign sel     = reg_sel_e'(addr[3:2]);
  assign wr_ctrl = we && (sel == SEL_CTRL);
  assign wr_per  = we && (sel == SEL_PER);
  assign wr_duty = we && (sel == SEL_DUTY);
  assign wr_stop = we && (sel == SEL_STOP);

  assign auto_on  = ctrl_q[AS_BIT];
  assign stop_hit = period_end && auto_on && (stop_q <= STOP_W'(1));
  assign stop_evt = stop_hit && !wr_ctrl;
  assign dec_evt  = period_end && auto_on && (stop_q > STOP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
      stop_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata[CTRL_W-1:0];
        pend_q <= 1'b0;
      end else if (stop_evt) begin
        ctrl_q[EN_BIT] <= 1'b0;
        pend_q         <= 1'b1;
      end
      if (wr_per)  per_q  <= wdata[PER_W-1:0];
      if (wr_duty) duty_q <= wdata[PER_W-1:0];
      if (wr_stop)       stop_q <= wdata[STOP_W-1:0];
      else if (stop_hit) stop_q <= '0;
      else if (dec_evt)  stop_q <= stop_q - 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: rdata = DATA_W'(ctrl_q);
      SEL_PER:  rdata = DATA_W'(per_q);
      SEL_DUTY: rdata = DATA_W'(duty_q);
      SEL_STOP: rdata = DATA_W'(stop_q);
      default:  rdata = '0;
    endcase
  end

  assign en       = ctrl_q[EN_BIT];
  assign irq_mask = ctrl_q[MASK_BIT];
  assign rate     = ctrl_q[RATE_W-1:0];
  assign period   = per_q;
  assign duty     = duty_q;
  assign pending  = pend_q;

  AST_STOP_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!ctrl_q[EN_BIT] && pend_q)); // R9

  AST_STOP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !wr_stop) |=> stop_q == $past(stop_q) - 1'b1); // R8

  AST_NO_AUTOSTOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_on && !wr_stop) |=> $stable(stop_q)); // R12

  AST_CTRL_WRITE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !pend_q); // R11

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              led_out,
  output logic              irq
);

  localparam int CTRL_W = MASK_BIT + 1;

  logic              en, irq_mask, pending, tick, period_end;
  logic [RATE_W-1:0] rate;
  logic [PER_W-1:0]  period, duty, count;

  led_blink_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .PER_W(PER_W), .STOP_W(STOP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .period_end(period_end),
    .en(en), .irq_mask(irq_mask), .rate(rate), .period(period),
    .duty(duty), .pending(pending)
  );

  led_blink_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .rate(rate), .tick(tick)
  );

  led_blink_waveform #(.PER_W(PER_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .period(period),
    .duty(duty), .count(count), .period_end(period_end), .led(led_out)
  );

  assign irq = pending && !irq_mask;

  AST_LED_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !led_out); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R10

  AST_FAST_RATE_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rate >= RATE_W'(MAX_LOG2)) |-> tick); // R4

endmodule

// File: tb/test_led_blink_ctrl.sv
`timescale 1ns/1ps
module test_led_blink_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        led_out, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  led_blink_ctrl i_led_blink_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_out(led_out), .irq(irq)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_DUTY = 4'h8, A_STOP = 4'hC;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic int exp_div(input int n);
    int e;
    e = (n > 13) ? 13 : n;
    return 1 << (13 - e);
  endfunction

  function automatic int exp_led(input int t, input int n, input int p, input int d);
    return (((t / exp_div(n)) % (p + 1)) < d) ? 1 : 0;
  endfunction

  // one configured run, checked every clock
  task automatic run(input int n, input int p, input int d, input int cnt,
                     input bit as, input bit mk);
    int len, per_clk, stop_after, v, ctrl;
    per_clk    = (p + 1) * exp_div(n);
    stop_after = ((cnt < 1) ? 1 : cnt) * per_clk;
    len        = as ? stop_after + per_clk : 3 * per_clk;
    ctrl       = (int'(mk) << 6) | (int'(as) << 5) | (1 << 4) | n;
    wr(A_CTRL, 16'h0000);
    wr(A_PER, 16'(p));
    wr(A_DUTY, 16'(d));
    wr(A_STOP, 16'(cnt));
    wr(A_CTRL, 16'(ctrl));
    for (int t = 0; t <= len; t++) begin
      if (as && t >= stop_after) begin
        check("R9 led after stop", int'(led_out), 0);
        check("R10 irq after stop", int'(irq), mk ? 0 : 1);
      end else begin
        check("R6 led pattern (R3 R4 R5)", int'(led_out), exp_led(t, n, p, d));
        check("R10 irq before stop", int'(irq), 0);
      end
      @(negedge clk);
    end
    rd(A_STOP, v);
    if (as) check("R8 remaining count", v, 0);
    else    check("R12 count unchanged", v, cnt);
    rd(A_CTRL, v);
    check("R9 enable bit state", (v >> 4) & 1, as ? 0 : 1);
    check("R4 control readback", v & 32'h4F, ctrl & 32'h4F);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed1ed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 led", int'(led_out), 0);
    check("R1 irq", int'(irq), 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PER, v);  check("R1 period", v, 0);
    rd(A_DUTY, v); check("R1 duty", v, 0);
    rd(A_STOP, v); check("R1 stop", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 widths
    wr(A_CTRL, 16'hFFEF);
    wr(A_PER, 16'hFFFF);
    wr(A_DUTY, 16'hFFFF);
    wr(A_STOP, 16'hFFFF);
    rd(A_CTRL, v); check("R2 ctrl width", v, 16'h006F);
    rd(A_PER, v);  check("R2 period width", v, 16'h0FFF);
    rd(A_DUTY, v); check("R2 duty width", v, 16'h0FFF);
    rd(A_STOP, v); check("R2 stop width", v, 16'hFFFF);

    // R6 edges: duty 0 dark, duty above period lit
    run(13, 3, 0, 0, 0, 0);
    run(13, 3, 9, 0, 0, 0);
    // R9 stop after three periods, count 0 stops after one
    run(13, 2, 2, 3, 1, 0);
    // R11 control write clears pending
    check("R11 irq set before ack", int'(irq), 1);
    wr(A_CTRL, 16'h0000);
    check("R11 irq cleared", int'(irq), 0);
    run(12, 1, 1, 0, 1, 0);
    // R10 masked stop
    run(13, 4, 2, 2, 1, 1);
    // R8 mid-run remaining count
    wr(A_CTRL, 16'h0000);
    wr(A_PER, 16'd1);
    wr(A_DUTY, 16'd1);
    wr(A_STOP, 16'd5);
    wr(A_CTRL, 16'h003D);
    repeat (4) @(negedge clk);
    rd(A_STOP, v); check("R8 after two periods", v, 3);
    // R7 disable darkens LED and re-enable starts at count 0
    wr(A_CTRL, 16'h000D);
    check("R7 led off", int'(led_out), 0);
    repeat (3) @(negedge clk);
    check("R7 led held off", int'(led_out), 0);

    // R3 slowest rate, first tick boundary
    wr(A_CTRL, 16'h0000);
    wr(A_PER, 16'd1);
    wr(A_DUTY, 16'd1);
    wr(A_CTRL, 16'h0010);
    repeat (8191) @(negedge clk);
    check("R3 rate 0 before tick", int'(led_out), 1);
    @(negedge clk);
    check("R3 rate 0 after tick", int'(led_out), 0);

    // random mix (R3 R4 R5 R6 R8 R9 R10 R12)
    for (int i = 0; i < 40; i++) begin
      int n, p, d, c;
      bit as, mk;
      n  = 10 + int'($urandom_range(0, 5));
      p  = int'($urandom_range(0, 15));
      d  = int'($urandom_range(0, 20));
      c  = int'($urandom_range(0, 3));
      as = 1'($urandom_range(0, 1));
      mk = 1'($urandom_range(0, 1));
      run(n, p, d, c, as, mk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule